// File: doc/BRIEF.md
# Floating-Point Control Register Move and Rounding-Mode Set Unit

This block keeps a 64-bit floating-point status and control register and executes four move-from operations on it. A full read returns the whole register. A light read returns only the rounding, status and enable fields. Two set-and-read operations return the rounding and enable fields and also replace the binary rounding mode. One takes the new mode from the low two bits of a 64-bit source operand. The other takes it from a 2-bit immediate, which the decoder pulls from bits 12:11 of the instruction word.

The set-and-read operations depend on two flags. If the ISA-level flag marks a level older than 3.0, they act as a plain full read. If the level is new enough but the FPU-enable flag is low, they raise an FPU-unavailable strobe in place of a result. The register can also be written whole through a load port, which only acts in a cycle with no operation. Each result, and any register change, lands one clock after the operation is accepted.

Top module: `fp_ctl_move_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the register, `result`, `resultValid` and `fpuUnavail` to zero.
- R2: With `loadEn` high and `opValid` low, the register takes all 64 bits of `loadData` at the clock edge. If `opValid` is high in the same cycle, `loadData` is ignored.
- R3: Full read (`opSel`=0) puts the whole register on `result`, and pulses `resultValid` for one cycle, one clock after acceptance.
- R4: Light read (`opSel`=1) returns the register ANDed with 0x0000_0007_0007_F0FB. That mask covers decimal rounding bits 34:32, status bits 18:12, enable bits 7:3 and binary rounding bits 1:0. All other bits read as zero.
- R5: A set-and-read that is allowed returns the register ANDed with 0x0000_0007_0000_00FB. Status bits 18:12 read as zero.
- R6: A set-and-read that is allowed changes only register bits 1:0. An operation issued in the next cycle sees the new value.
- R7: The operand variant (`opSel`=2) takes the new rounding mode from `srcOperand[1:0]` and ignores bits 63:2.
- R8: The immediate variant (`opSel`=3) takes the new rounding mode from `immRm`.
- R9: With `isaModern` low, both set-and-read operations return the full unmasked register and leave it unchanged, whatever `fpuEnable` is.
- R10: With `isaModern` high and `fpuEnable` low, a set-and-read pulses `fpuUnavail` one clock later. It gives no `resultValid` and does not change the register.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation issued this cycle |
| opSel | input | 2 | 0 full read, 1 light read, 2 set from operand, 3 set from immediate |
| srcOperand | input | 64 | Source register operand for the operand variant |
| immRm | input | 2 | Rounding-mode immediate, taken from instruction bits 12:11 |
| isaModern | input | 1 | High when the ISA level is 3.0 or later |
| fpuEnable | input | 1 | High when the FPU is usable |
| loadEn | input | 1 | Load the whole register |
| loadData | input | 64 | Value for the load port |
| result | output | 64 | Result of the last accepted operation |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| fpuUnavail | output | 1 | One-cycle FPU-unavailable exception strobe |

## Verification
The register is loaded with all ones, with alternating-bit patterns and with zero. All ones shows each read mask exactly. The alternating patterns catch a field placed at the wrong offset, because neighbouring bits differ.

Set-and-read operations are run with source operands whose upper bits are all set, and each is followed at once by a full read. This separates a correct change of bits 1:0 from one that also clears other bits or copies operand bits in. Running the same operations with the ISA flag low, and with the FPU disabled, shows the fallback read apart from the exception path. Issuing a load in the same cycle as an operation confirms that the operation wins.

// File: rtl/fp_ctl_pkg.sv
package fp_ctl_pkg;

  localparam int DATA_W   = 64;
  localparam int RN_LSB   = 0;
  localparam int RN_W     = 2;
  localparam int EN_LSB   = 3;
  localparam int EN_W     = 5;
  localparam int STAT_LSB = 12;
  localparam int STAT_W   = 7;
  localparam int DRN_LSB  = 32;
  localparam int DRN_W    = 3;

  typedef enum logic [1:0] {
    OP_FULL    = 2'd0,
    OP_LIGHT   = 2'd1,
    OP_SET_SRC = 2'd2,
    OP_SET_IMM = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    RES_FULL  = 2'd0,
    RES_LIGHT = 2'd1,
    RES_SET   = 2'd2
  } resSel_e;

  typedef struct packed {
    logic    capture;
    logic    loadReg;
    logic    writeRn;
    logic    rnFromImm;
    resSel_e resSel;
  } ctrlStrb_t;

  function automatic logic [DATA_W-1:0] fieldMask(input int lsb, input int width);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] SET_MASK =
    fieldMask(DRN_LSB, DRN_W) | fieldMask(EN_LSB, EN_W) | fieldMask(RN_LSB, RN_W);
  localparam logic [DATA_W-1:0] LIGHT_MASK = SET_MASK | fieldMask(STAT_LSB, STAT_W);

endpackage

// File: rtl/fp_ctl_move_ctrl.sv
module fp_ctl_move_ctrl
  import fp_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opValid,
  input  logic [1:0] opSel,
  input  logic       isaModern,
  input  logic       fpuEnable,
  input  logic       loadEn,
  output ctrlStrb_t  strb,
  output logic       resultValid,
  output logic       fpuUnavail
);

  opKind_e opKind;
  logic    isSetOp;
  logic    setAllowed;
  logic    trapNow;

  assign opKind     = opKind_e'(opSel);
  assign isSetOp    = (opKind == OP_SET_SRC) || (opKind == OP_SET_IMM);
  assign setAllowed = isSetOp && isaModern && fpuEnable;
  assign trapNow    = opValid && isSetOp && isaModern && !fpuEnable;

  always_comb begin
    strb           = '0;
    strb.resSel    = RES_FULL;
    strb.loadReg   = loadEn && !opValid;
    if (opValid) begin
      unique case (opKind)
        OP_FULL:  strb.capture = 1'b1;
        OP_LIGHT: begin
          strb.capture = 1'b1;
          strb.resSel  = RES_LIGHT;
        end
        default: begin
          if (!isaModern) begin
            strb.capture = 1'b1;
          end else if (setAllowed) begin
            strb.capture   = 1'b1;
            strb.resSel    = RES_SET;
            strb.writeRn   = 1'b1;
            strb.rnFromImm = (opKind == OP_SET_IMM);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      fpuUnavail  <= 1'b0;
    end else begin
      resultValid <= strb.capture;
      fpuUnavail  <= trapNow;
    end
  end

endmodule

// File: rtl/fp_ctl_move_dp.sv
module fp_ctl_move_dp
  import fp_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [RN_W-1:0]   immRm,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] resNext;
  logic [RN_W-1:0]   newRn;

  assign newRn = strb.rnFromImm ? immRm : srcOperand[RN_LSB +: RN_W];

  always_comb begin
    unique case (strb.resSel)
      RES_LIGHT: resNext = statReg & LIGHT_MASK;
      RES_SET:   resNext = statReg & SET_MASK;
      default:   resNext = statReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statReg <= '0;
      result  <= '0;
    end else begin
      if (strb.writeRn)      statReg[RN_LSB +: RN_W] <= newRn;
      else if (strb.loadReg) statReg <= loadData;
      if (strb.capture)      result <= resNext;
    end
  end

endmodule

// File: rtl/fp_ctl_move_unit.sv
module fp_ctl_move_unit
  import fp_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [1:0]  opSel,
  input  logic [63:0] srcOperand,
  input  logic [1:0]  immRm,
  input  logic        isaModern,
  input  logic        fpuEnable,
  input  logic        loadEn,
  input  logic [63:0] loadData,
  output logic [63:0] result,
  output logic        resultValid,
  output logic        fpuUnavail
);

  ctrlStrb_t strb;

  fp_ctl_move_ctrl i_ctrl (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel),
    .isaModern(isaModern), .fpuEnable(fpuEnable), .loadEn(loadEn),
    .strb(strb), .resultValid(resultValid), .fpuUnavail(fpuUnavail)
  );

  fp_ctl_move_dp i_dp (
    .clk(clk), .rst(rst), .strb(strb), .srcOperand(srcOperand),
    .immRm(immRm), .loadData(loadData), .result(result)
  );

endmodule

// File: rtl/fp_ctl_move_chk.sv
module fp_ctl_move_chk
  import fp_ctl_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        opValid,
  input logic [1:0]  opSel,
  input logic [63:0] srcOperand,
  input logic [1:0]  immRm,
  input logic        isaModern,
  input logic        fpuEnable,
  input logic        loadEn,
  input logic [63:0] loadData,
  input logic [63:0] result,
  input logic        resultValid,
  input logic        fpuUnavail
);

  // R3: a full read yields a valid result one clock later
  assert_full_read_valid_R3: assert property (@(posedge clk) disable iff (rst)
    opValid && opSel == 2'd0 |=> resultValid && !fpuUnavail);

  // R4: light read shows nothing outside its mask
  assert_light_mask_R4: assert property (@(posedge clk) disable iff (rst)
    opValid && opSel == 2'd1 |=> resultValid && ((result & ~LIGHT_MASK) == '0));

  // R5: an allowed set-and-read shows nothing outside its mask
  assert_set_mask_R5: assert property (@(posedge clk) disable iff (rst)
    opValid && opSel[1] && isaModern && fpuEnable |=>
      resultValid && ((result & ~SET_MASK) == '0));

  // R6 / R8: an immediate set is seen by a full read in the following cycle
  assert_rn_visible_R6: assert property (@(posedge clk) disable iff (rst)
    opValid && opSel == 2'd3 && isaModern && fpuEnable ##1 opValid && opSel == 2'd0
      |=> result[1:0] == $past(immRm, 2));

  // R10: a disabled FPU traps in place of a result
  assert_unavail_trap_R10: assert property (@(posedge clk) disable iff (rst)
    opValid && opSel[1] && isaModern && !fpuEnable |=> fpuUnavail && !resultValid);

  // R10: the two strobes never coincide
  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(resultValid && fpuUnavail));

endmodule

bind fp_ctl_move_unit fp_ctl_move_chk i_chk (.*);

// File: tb/test_fp_ctl_move_unit.sv
module test_fp_ctl_move_unit;

  localparam logic [63:0] LIGHT_M = 64'h0000_0007_0007_F0FB;
  localparam logic [63:0] SET_M   = 64'h0000_0007_0000_00FB;

  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [1:0]  opSel;
  logic [63:0] srcOperand;
  logic [1:0]  immRm;
  logic        isaModern;
  logic        fpuEnable;
  logic        loadEn;
  logic [63:0] loadData;
  logic [63:0] result;
  logic        resultValid;
  logic        fpuUnavail;

  always #2.5 clk = ~clk;

  fp_ctl_move_unit i_fp_ctl_move_unit (.*);

  typedef struct {
    logic        valid;
    logic        unavail;
    logic [63:0] value;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [63:0] mdl;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic idle();
    opValid = 0; loadEn = 0; opSel = 0; srcOperand = '0; immRm = 0;
    loadData = '0;
  endtask

  task automatic doLoad(input logic [63:0] v);
    @(negedge clk);
    idle();
    loadEn = 1; loadData = v;
    mdl = v;
  endtask

  task automatic doOp(input logic [1:0] sel, input logic [63:0] src,
                      input logic [1:0] imm, input logic isa, input logic en,
                      input bit alsoLoad, input string tag);
    expItem_t e;
    @(negedge clk);
    idle();
    opValid = 1; opSel = sel; srcOperand = src; immRm = imm;
    isaModern = isa; fpuEnable = en;
    if (alsoLoad) begin loadEn = 1; loadData = ~mdl; end
    e.tag = tag; e.valid = 1; e.unavail = 0;
    case (sel)
      2'd0: e.value = mdl;
      2'd1: e.value = mdl & LIGHT_M;
      default: begin
        if (!isa) e.value = mdl;
        else if (!en) begin e.valid = 0; e.unavail = 1; e.value = 'x; end
        else begin
          e.value = mdl & SET_M;
          mdl = {mdl[63:2], (sel == 2'd3) ? imm : src[1:0]};
        end
      end
    endcase
    expQ.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          checks++;
          if (resultValid !== e.valid || fpuUnavail !== e.unavail ||
              (e.valid && result !== e.value)) begin
            errors++;
            $display("FAIL %s: got valid=%0b unavail=%0b result=%h, expected valid=%0b unavail=%0b result=%h",
                     e.tag, resultValid, fpuUnavail, result, e.valid, e.unavail, e.value);
          end
        end else if (resultValid || fpuUnavail) begin
          checks++; errors++;
          $display("FAIL R3: got unexpected strobe valid=%0b unavail=%0b, expected none",
                   resultValid, fpuUnavail);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    idle(); isaModern = 1; fpuEnable = 1; rst = 1; mdl = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    checks++;
    if (result !== '0 || resultValid !== 0 || fpuUnavail !== 0) begin
      errors++;
      $display("FAIL R1: got result=%h valid=%0b unavail=%0b, expected all zero",
               result, resultValid, fpuUnavail);
    end
    doOp(2'd0, '0, 0, 1, 1, 0, "R1 register zero after reset");

    doLoad('1);
    doOp(2'd0, '0, 0, 1, 1, 0, "R2 R3 full read of all ones");
    doOp(2'd1, '0, 0, 1, 1, 0, "R4 light read of all ones");
    doOp(2'd2, 64'hFFFF_FFFF_FFFF_FFFC, 0, 1, 1, 0, "R5 R7 operand set");
    doOp(2'd0, '0, 0, 1, 1, 0, "R6 R7 read after operand set");
    doOp(2'd3, '1, 2'd2, 1, 1, 0, "R5 R8 immediate set");
    doOp(2'd0, '0, 0, 1, 1, 0, "R6 R8 read after immediate set");

    doLoad(64'hA5A5_5A5A_0F0F_F0F1);
    doOp(2'd1, '0, 0, 1, 1, 0, "R4 light read pattern A");
    doOp(2'd2, 64'h5555_5555_5555_5556, 0, 1, 1, 0, "R7 operand set high bits ignored");
    doOp(2'd0, '0, 0, 1, 1, 0, "R6 R7 full read pattern A");
    doLoad(64'h5A5A_A5A5_F0F0_0F0E);
    doOp(2'd1, '0, 0, 1, 1, 0, "R4 light read pattern B");
    doOp(2'd3, '0, 2'd1, 1, 1, 0, "R8 immediate set pattern B");
    doOp(2'd0, '0, 0, 1, 1, 0, "R6 R8 full read pattern B");

    doOp(2'd2, 64'h3, 0, 0, 1, 0, "R9 legacy operand set");
    doOp(2'd3, '0, 2'd3, 0, 0, 0, "R9 legacy immediate set");
    doOp(2'd0, '0, 0, 1, 1, 0, "R9 register unchanged");

    doOp(2'd2, 64'h1, 0, 1, 0, 0, "R10 disabled operand set");
    doOp(2'd3, '0, 2'd0, 1, 0, 0, "R10 disabled immediate set");
    doOp(2'd0, '0, 0, 1, 1, 0, "R10 register unchanged");

    doOp(2'd0, '0, 0, 1, 1, 1, "R2 load with op ignored");
    doOp(2'd0, '0, 0, 1, 1, 0, "R2 register kept after ignored load");

    doLoad('0);
    doOp(2'd1, '0, 0, 1, 1, 0, "R4 light read of zero");
    doOp(2'd3, '0, 2'd3, 1, 1, 0, "R8 immediate set on zero");
    doOp(2'd1, '0, 0, 1, 1, 0, "R6 light read sees new mode");

    settle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule